// File: doc/BRIEF.md
# Byte-per-Cycle Carry-Save Multiply-Accumulate Unit

This block multiplies two 32-bit operands and optionally adds a 32-bit accumulate value. The result is the low 32 bits of the sum. The multiplier operand is consumed one byte per clock. Four cascaded carry-save layers each apply one radix-4 Booth digit, so a full operand needs at most four iteration cycles. The redundant running total is kept as a sum word and a carry word. At the start of an operation the sum word is loaded with the accumulate value or with zero. A single carry-propagate addition at the end merges the two words into the result.

The multiplier is treated as a two's-complement number. Iteration stops as soon as the bytes that remain are pure sign extension of the bytes already consumed. Short operands therefore finish in fewer cycles. The low 32 bits of a product are the same for signed and unsigned readings of the operands, so the block serves both.

To use it, drive the operands and pulse `start` for one cycle while the unit is idle. Then wait for `done`.

Top module: `csa_mac8`

## Requirements
- R1: When `done` is high, `result` equals the low 32 bits of `mcand_in * mplier_in + (acc_en ? acc_in : 0)`, using the values sampled on the clock edge where `start` was accepted.
- R2: When `acc_en` is low at the accepted start, `acc_in` has no effect on `result`.
- R3: `done` is high for exactly one cycle per operation. `result` changes only on the edge that raises `done`, and it holds its value between operations.
- R4: If `start` is accepted on edge E, `done` rises on edge E+N+1, where N is the number of iteration cycles.
- R5: N is the smallest k in 1..3 for which `mplier_in`, read as a signed number, fits in 8*k bits. In other words, bits 31 down to 8*k-1 must all be equal. Otherwise N is 4. Examples: 0x0000007F and 0xFFFFFF80 give N=1, 0x00000080 gives N=2, and 0x12345678 gives N=4.
- R6: A `start` pulse that arrives while an operation is in progress is ignored. It neither changes that operation's result or timing nor produces an extra `done`.
- R7: During and after a synchronous active-low reset, `done` is 0 and `result` is 0.
- R8: An operation occupies the unit for at most five cycles: up to four iteration cycles plus one merge cycle.
- R9: Each layer selects its Booth digit from three overlapping multiplier bits {high, mid, low}. The mapping is 000→0, 001→+1, 010→+1, 011→+2, 100→−2, 101→−1, 110→−1 and 111→0. The low bit of the lowest layer is the top bit of the previous byte, or 0 in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| acc_en | input | 1 | Add `acc_in` to the product |
| mcand_in | input | 32 | Multiplicand |
| mplier_in | input | 32 | Multiplier, consumed a byte per cycle |
| acc_in | input | 32 | Accumulate value |
| result | output | 32 | Low 32 bits of product plus accumulate |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench aims at multipliers whose top byte boundaries sit right at the termination rule.

- Values such as 0x7F, 0x80, 0xFFFFFF80, 0xFFFF7FFF and 0x80000000 probe the boundaries. A wrong termination test either finishes one cycle early and drops a byte, giving a wrong product, or runs extra cycles, which the cycle count exposes.
- Multipliers of all ones and alternating patterns exercise every Booth digit, including −2 and the 111 group. A layer with a wrong sign injection or a wrong doubling shift gives results off by the multiplicand.
- Accumulate with and without enable, a second `start` sent mid-operation, and idle periods with changing inputs expose a block that leaks `acc_in`, restarts, or lets `result` drift.

// File: rtl/csa_mac8_pkg.sv
// Shared types and the Booth digit decode for the byte-per-cycle MAC.
// Assumes radix-4 recoding: each digit comes from three overlapping bits.
package csa_mac8_pkg;

    // Booth digit: magnitude one, magnitude two, and a negate flag
    typedef struct packed {
        logic neg;
        logic dbl;
        logic sgl;
    } booth_dig_t;

    // Map a group {high, mid, low} to its signed digit in {-2..+2}
    function automatic booth_dig_t booth_decode(input logic [2:0] grp);
        booth_dig_t d;
        d = '0;
        case (grp)
            3'b001, 3'b010: d.sgl = 1'b1;
            3'b011:         d.dbl = 1'b1;
            3'b100: begin
                d.dbl = 1'b1;
                d.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                d.sgl = 1'b1;
                d.neg = 1'b1;
            end
            default:        d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/csa_mac8_booth.sv
// Booth recoder for one multiplier window.
// Splits the window into 2-bit slices. Each slice is extended downward by
// one bit, and that bit comes from the slice below or, for the lowest
// slice, from the overlap bit kept from the previous cycle.
module csa_mac8_booth
    import csa_mac8_pkg::*;
#(
    parameter int WIN_W  = 8,
    localparam int LAYERS = WIN_W / 2
) (
    input  logic [WIN_W-1:0]        win,
    input  logic                    ovl,
    output booth_dig_t [LAYERS-1:0] digs
);

    // Window extended with the overlap bit below bit 0
    logic [WIN_W:0] ext;
    assign ext = {win, ovl};

    // One decoder per layer, reading three overlapping bits
    for (genvar j = 0; j < LAYERS; j++) begin : g_dec
        assign digs[j] = booth_decode(ext[2*j+2 : 2*j]);
    end

endmodule

// File: rtl/csa_mac8_csa_layer.sv
// One carry-save layer. It adds the multiplicand, scaled by one Booth digit
// and a fixed shift, into a redundant (sum, carry) pair.
// A negative digit adds the bitwise inverse of the scaled multiplicand and
// puts the +1 into the carry LSB, which the left shift of the carries
// leaves free. All arithmetic is modulo 2^W.
module csa_mac8_csa_layer
    import csa_mac8_pkg::*;
#(
    parameter int W     = 32,
    parameter int SHIFT = 0
) (
    input  logic [W-1:0] sum_in,
    input  logic [W-1:0] carry_in,
    input  logic [W-1:0] mcand,
    input  booth_dig_t   dig,
    output logic [W-1:0] sum_out,
    output logic [W-1:0] carry_out
);

    logic [W-1:0] mag;
    logic [W-1:0] addend;
    logic [W-1:0] maj;

    // Select the digit magnitude (0, 1x or 2x) at this layer's weight
    always_comb begin
        if (dig.dbl)      mag = mcand << (SHIFT + 1);
        else if (dig.sgl) mag = mcand << SHIFT;
        else              mag = '0;
    end

    // Invert for a negative digit; the matching +1 goes into carry bit 0
    assign addend = dig.neg ? ~mag : mag;

    // 3:2 compression: bitwise sum and majority carries
    assign sum_out   = sum_in ^ carry_in ^ addend;
    assign maj       = (sum_in & carry_in) | (sum_in & addend) | (carry_in & addend);
    assign carry_out = {maj[W-2:0], dig.neg};

endmodule

// File: rtl/csa_mac8_ctrl.sv
// Sequencer for the MAC. It holds the multiplier shift register and the
// overlap bit, counts iterations and decides when to stop.
// Termination: stop once the bytes still to come are pure sign extension
// of the top bit just consumed, or after the last byte.
module csa_mac8_ctrl #(
    parameter int W        = 32,
    parameter int WIN_W    = 8,
    localparam int MAX_ITER = W / WIN_W,
    localparam int CNT_W    = $clog2(MAX_ITER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     mplier,
    output logic             load,
    output logic             step,
    output logic             merge,
    output logic             busy,
    output logic [WIN_W-1:0] win,
    output logic             ovl
);

    typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_MERGE} st_t;

    st_t              st_q;
    logic [W-1:0]     rs_q;
    logic             ovl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     rs_next;
    logic             rest_idle;
    logic             last;

    // Strobes to the datapath, decoded from the state
    assign load  = (st_q == ST_IDLE) && start;
    assign step  = (st_q == ST_ITER);
    assign merge = (st_q == ST_MERGE);
    assign busy  = (st_q != ST_IDLE);
    assign win   = rs_q[WIN_W-1:0];
    assign ovl   = ovl_q;

    // Next multiplier contents and the early-stop test
    assign rs_next   = W'($signed(rs_q) >>> WIN_W);
    assign rest_idle = (rs_next == {W{rs_q[WIN_W-1]}});
    assign last      = rest_idle || (cnt_q == CNT_W'(MAX_ITER - 1));

    // State, multiplier shift register, overlap bit and iteration count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            rs_q  <= '0;
            ovl_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    st_q  <= ST_ITER;
                    rs_q  <= mplier;
                    ovl_q <= 1'b0;
                    cnt_q <= '0;
                end
                ST_ITER: begin
                    rs_q  <= rs_next;
                    ovl_q <= rs_q[WIN_W-1];
                    cnt_q <= cnt_q + 1'b1;
                    if (last) st_q <= ST_MERGE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/csa_mac8.sv
// Top of the byte-per-cycle carry-save multiply-accumulate unit.
// Assumes one operation at a time. Operands are captured on an accepted
// start. The redundant total is held as sum and carry words. Instead of
// rotating the total, the multiplicand is shifted left one byte per cycle,
// so the adder array sees a fixed window. Returns the low W bits.
module csa_mac8
    import csa_mac8_pkg::*;
#(
    parameter int W     = 32,
    parameter int WIN_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         acc_en,
    input  logic [31:0]  mcand_in,
    input  logic [31:0]  mplier_in,
    input  logic [31:0]  acc_in,
    output logic [31:0]  result,
    output logic         done
);

    localparam int LAYERS = WIN_W / 2;

    logic             load;
    logic             step;
    logic             merge;
    logic             busy;
    logic [WIN_W-1:0] win;
    logic             ovl;
    booth_dig_t [LAYERS-1:0] digs;

    logic [W-1:0] sum_q;
    logic [W-1:0] carry_q;
    logic [W-1:0] mcand_q;
    logic [W-1:0] result_q;
    logic         done_q;

    logic [W-1:0] s_chain [LAYERS+1];
    logic [W-1:0] c_chain [LAYERS+1];

    csa_mac8_ctrl #(.W(W), .WIN_W(WIN_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mplier (mplier_in),
        .load   (load),
        .step   (step),
        .merge  (merge),
        .busy   (busy),
        .win    (win),
        .ovl    (ovl)
    );

    csa_mac8_booth #(.WIN_W(WIN_W)) u_booth (
        .win  (win),
        .ovl  (ovl),
        .digs (digs)
    );

    // Feed the array with the running redundant total
    assign s_chain[0] = sum_q;
    assign c_chain[0] = carry_q;

    // Cascade of carry-save layers, each two multiplier bits further up
    for (genvar j = 0; j < LAYERS; j++) begin : g_layer
        csa_mac8_csa_layer #(.W(W), .SHIFT(2*j)) u_layer (
            .sum_in    (s_chain[j]),
            .carry_in  (c_chain[j]),
            .mcand     (mcand_q),
            .dig       (digs[j]),
            .sum_out   (s_chain[j+1]),
            .carry_out (c_chain[j+1])
        );
    end

    // Redundant total and multiplicand alignment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            carry_q <= '0;
            mcand_q <= '0;
        end else if (load) begin
            sum_q   <= acc_en ? acc_in : '0;
            carry_q <= '0;
            mcand_q <= mcand_in;
        end else if (step) begin
            sum_q   <= s_chain[LAYERS];
            carry_q <= c_chain[LAYERS];
            mcand_q <= mcand_q << WIN_W;
        end
    end

    // Final carry-propagate merge and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= merge;
            if (merge) result_q <= sum_q + carry_q;
        end
    end

    assign result = result_q;
    assign done   = done_q;

endmodule

// File: rtl/csa_mac8_chk.sv
// Protocol checker for csa_mac8, attached by bind. It checks the shape of
// the done pulse, that the result holds between operations, that work
// starts only on a start request, and the cycle bound.
module csa_mac8_chk #(
    parameter int MAX_BUSY = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] result
);

    logic [3:0] busy_cnt;

    // Count consecutive busy cycles for the occupancy bound
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    // R3: done lasts exactly one cycle
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: result moves only together with done
    assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R4: done only ever follows a busy cycle
    assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R6: the unit leaves idle only on a start request
    assert_start_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8: an operation never stays busy longer than the bound
    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 4'(MAX_BUSY));

endmodule

bind csa_mac8 csa_mac8_chk #(.MAX_BUSY(W / WIN_W + 1)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/sim_csa_mac8.sv
// Directed bench for csa_mac8: one task per scenario, each checking itself.
module sim_csa_mac8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        acc_en = 1'b0;
    logic [31:0] mcand_in = '0;
    logic [31:0] mplier_in = '0;
    logic [31:0] acc_in = '0;
    logic [31:0] result;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    csa_mac8 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .acc_en    (acc_en),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .acc_in    (acc_in),
        .result    (result),
        .done      (done)
    );

    // Record one check
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Iteration count from the sign-extension rule of R5
    function automatic int exp_iters(input logic [31:0] rs);
        for (int k = 1; k < 4; k++) begin
            logic signed [31:0] t;
            t = $signed(rs) >>> (8*k - 1);
            if (t == 0 || t == -1) return k;
        end
        return 4;
    endfunction

    // Run one operation; return the edges from accept to done (R4, R5)
    task automatic run_op(input logic [31:0] m, input logic [31:0] r, input logic [31:0] a,
                          input logic en, output int edges);
        @(negedge clk);
        mcand_in = m; mplier_in = r; acc_in = a; acc_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        while (!done && edges < 20) begin
            @(negedge clk);
            edges++;
        end
    endtask

    // R1, R2, R4, R5: one operation, checking value and latency
    task automatic do_op(input logic [31:0] m, input logic [31:0] r, input logic [31:0] a,
                         input logic en, input string tag);
        int e;
        logic [31:0] expv;
        expv = m * r + (en ? a : 32'd0);
        run_op(m, r, a, en, e);
        chk(result == expv, {"R1 ", tag}, result, expv);
        chk(e == exp_iters(r) + 1, {"R4 R5 ", tag}, 32'(e), 32'(exp_iters(r) + 1));
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R7 done", {31'd0, done}, 32'd0);
        chk(result == 32'd0, "R7 result", result, 32'd0);
    endtask

    task automatic t_booth_corners();
        do_op(32'd29, 32'd43, 32'd0, 1'b0, "small");
        do_op(32'h12345678, 32'hFFFFFFFF, 32'd0, 1'b0, "R9 all ones");
        do_op(32'hDEADBEEF, 32'hAAAAAAAA, 32'd0, 1'b0, "R9 alternating");
        do_op(32'h0F0F0F0F, 32'h55555555, 32'd0, 1'b0, "R9 alternating b");
        do_op(32'h89ABCDEF, 32'h66666666, 32'd0, 1'b0, "R9 twos");
        do_op(32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 1'b0, "max");
        do_op(32'h00000000, 32'h12345678, 32'd0, 1'b0, "zero mcand");
    endtask

    task automatic t_termination();
        do_op(32'h1357_9BDF, 32'h0000_0000, 32'd0, 1'b0, "R5 zero");
        do_op(32'h1357_9BDF, 32'h0000_007F, 32'd0, 1'b0, "R5 7F");
        do_op(32'h1357_9BDF, 32'h0000_0080, 32'd0, 1'b0, "R5 80");
        do_op(32'h1357_9BDF, 32'hFFFF_FF80, 32'd0, 1'b0, "R5 neg byte");
        do_op(32'h1357_9BDF, 32'hFFFF_FF7F, 32'd0, 1'b0, "R5 neg 2byte");
        do_op(32'h1357_9BDF, 32'hFFFF_7FFF, 32'd0, 1'b0, "R5 neg 3byte");
        do_op(32'h1357_9BDF, 32'h007F_FFFF, 32'd0, 1'b0, "R5 3byte");
        do_op(32'h1357_9BDF, 32'h0080_0000, 32'd0, 1'b0, "R5 4byte");
        do_op(32'h1357_9BDF, 32'h8000_0000, 32'd0, 1'b0, "R5 min");
        do_op(32'h1357_9BDF, 32'h1234_5678, 32'd0, 1'b0, "R5 full");
    endtask

    task automatic t_accumulate();
        do_op(32'd9, 32'd5, 32'h1000_0001, 1'b1, "R1 acc");
        do_op(32'hFFFF_FFFF, 32'd3, 32'h8000_0000, 1'b1, "R1 acc wrap");
        do_op(32'd9, 32'd5, 32'hABCD_1234, 1'b0, "R2 acc off");
        do_op(32'd7, 32'h0000_1000, 32'hFFFF_FFFF, 1'b0, "R2 acc off b");
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            logic [31:0] m, r, a;
            m = $urandom; r = $urandom; a = $urandom;
            if (i % 4 == 1) r = r >> 20;
            if (i % 4 == 2) r = r | 32'hFFFF_0000;
            do_op(m, r, a, 1'(i % 2), "R1 random");
        end
    endtask

    // R6: a start during an operation changes nothing
    task automatic t_busy_start();
        int e;
        logic [31:0] expv;
        expv = 32'h1234_5678 * 32'h0BAD_F00D + 32'd77;
        @(negedge clk);
        mcand_in = 32'h1234_5678; mplier_in = 32'h0BAD_F00D; acc_in = 32'd77; acc_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b1;
        mcand_in = 32'd3; mplier_in = 32'd3; acc_in = 32'd0; acc_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        e = 1;
        while (!done && e < 20) begin
            @(negedge clk);
            e++;
        end
        chk(result == expv, "R6 result", result, expv);
        chk(e == 5, "R6 latency", 32'(e), 32'd5);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!done, "R6 no extra done", {31'd0, done}, 32'd0);
        end
    endtask

    // R3: done is one pulse and result holds while idle
    task automatic t_hold();
        logic [31:0] keep;
        do_op(32'd100, 32'd200, 32'd0, 1'b0, "R3 setup");
        keep = result;
        @(negedge clk);
        chk(!done, "R3 pulse width", {31'd0, done}, 32'd0);
        mcand_in = 32'hFFFF_0000; mplier_in = 32'h0000_FFFF; acc_in = 32'h5555_5555; acc_en = 1'b1;
        for (int i = 0; i < 6; i++) @(negedge clk);
        chk(result == keep, "R3 hold", result, keep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_booth_corners();
        t_termination();
        t_accumulate();
        t_busy_start();
        t_hold();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule